// File: doc/BRIEF.md
# Lane-Crossing Game Rules Engine

This block decides the fate of the player sprite in a lane-crossing game. A separate frame accumulator ORs and ANDs per-pixel colour classes over the sprite's footprint during each video frame and gives the block a summary. The summary says whether every pixel is grass and whether any pixel is road. It also says whether a vehicle, a log or a goal object lies under the sprite, and which row the sprite is on. The block reads this summary once per frame, on a frame strobe, and moves between five states: grass, road, river, dead and win.

The outputs are Mealy style. A fatal frame raises `dead` in the same cycle as the strobe. `on_log` follows the current flags at all times. After a death, the block holds `dead` for a set number of frame strobes and then pulses `respawn`, so that the position logic returns the sprite to its start. Reaching the top row over a goal object gives a one-cycle `win` pulse. After a win or a respawn the block is back on grass.

Top module: `lane_crossing_rules`

## Requirements
- R1: A synchronous, active-high `rst` puts the block in the grass state and clears the death timer. With `frame_tick` low, every output is 0 in the cycle after reset.
- R2: Flags are only acted on when `frame_tick` = 1. Hazard flags seen without a strobe do not raise `dead` and do not change state.
- R3: When `bg_all_grass` = 1 the sprite is safe. In a live state, `dead` stays 0 whatever the object flags say.
- R4: Road means `bg_all_grass` = 0 and `bg_any_road` = 1. On road, a strobe with `obj_any_car` = 1 raises `dead` in that same cycle, and the state becomes dead.
- R5: On road with `obj_any_car` = 0, a strobe leaves the sprite alive.
- R6: Water means both background flags are 0. On water in a live state, `on_log` equals `obj_any_log`, with or without a strobe, and `dead` stays 0 while a log is present.
- R7: On water, a strobe with `obj_any_log` = 0 raises `dead` in that cycle and enters the dead state.
- R8: In the dead state, `dead` = 1 and `on_log` = 0. `respawn` is 1 only during the DEATH_FRAMES-th strobe after the fatal one.
- R9: Flags seen while dead are ignored: they neither restart nor stretch the timer. After the respawn cycle the block is alive on grass.
- R10: A strobe with `row_idx` = 0 and `obj_any_goal` = 1 in a live state sets `win` to 1 for exactly the next cycle and then returns to grass. Inputs during that cycle are ignored. A goal flag on any other row has no effect.
- R11: The goal test takes priority over the hazard tests. A winning strobe never raises `dead`, even on water with no log.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle strobe: frame flags are complete |
| bg_all_grass | input | 1 | Every footprint pixel has grass background |
| bg_any_road | input | 1 | At least one footprint pixel has road background |
| obj_any_car | input | 1 | At least one footprint pixel shows a vehicle |
| obj_any_log | input | 1 | At least one footprint pixel shows a log |
| obj_any_goal | input | 1 | At least one footprint pixel shows a goal object |
| row_idx | input | ROW_W | Sprite row, 0 = top (goal) row |
| dead | output | 1 | Player is dying / dead |
| respawn | output | 1 | One-cycle request to return the sprite to start |
| on_log | output | 1 | Sprite rides a log on water |
| win | output | 1 | One-cycle goal-reached pulse |

## Verification
The main stimulus is a stream of frame summaries. It moves through each terrain with the hazard object present and absent, so that a road death, a river death, a log save and a grass save each show up as a different output pattern. Hazard flags that arrive without a strobe, and hazards that arrive during the death count, separate a design that samples only on the strobe from one that reacts at any time or restarts its timer. A goal on a nonzero row, and a goal on row 0 over open water, show whether the goal check uses the row and whether it wins over the drowning rule. A reset part-way through a death, followed by a full death count, shows that the timer is cleared.

// File: rtl/lcr_pkg.sv
package lcr_pkg;

  typedef enum logic [2:0] {
    ST_GRASS = 3'd0,
    ST_ROAD  = 3'd1,
    ST_RIVER = 3'd2,
    ST_DEAD  = 3'd3,
    ST_WIN   = 3'd4
  } state_e;

  typedef enum logic [1:0] {
    TR_GRASS = 2'd0,
    TR_ROAD  = 2'd1,
    TR_WATER = 2'd2
  } terrain_e;

  // Grass wins over road; anything that is neither is water.
  function automatic terrain_e classify(input logic all_grass, input logic any_road);
    if (all_grass)     return TR_GRASS;
    else if (any_road) return TR_ROAD;
    else               return TR_WATER;
  endfunction

  function automatic logic is_fatal(input terrain_e tr, input logic car, input logic log_hit);
    case (tr)
      TR_ROAD:  return car;
      TR_WATER: return !log_hit;
      default:  return 1'b0;
    endcase
  endfunction

  function automatic state_e terrain_state(input terrain_e tr);
    case (tr)
      TR_ROAD:  return ST_ROAD;
      TR_WATER: return ST_RIVER;
      default:  return ST_GRASS;
    endcase
  endfunction

  function automatic logic is_alive(input state_e st);
    return (st == ST_GRASS) || (st == ST_ROAD) || (st == ST_RIVER);
  endfunction

endpackage

// File: rtl/lcr_terrain.sv
module lcr_terrain
  import lcr_pkg::*;
#(
  parameter int ROW_W = 4
) (
  input  logic             bg_all_grass,
  input  logic             bg_any_road,
  input  logic             obj_any_car,
  input  logic             obj_any_log,
  input  logic             obj_any_goal,
  input  logic [ROW_W-1:0] row_idx,
  output terrain_e         terrain,
  output logic             goal_hit,
  output logic             fatal,
  output logic             log_ride
);
  always_comb begin
    terrain  = classify(bg_all_grass, bg_any_road);
    goal_hit = obj_any_goal && (row_idx == '0);
    fatal    = is_fatal(terrain, obj_any_car, obj_any_log);
    log_ride = (terrain == TR_WATER) && obj_any_log;
  end
endmodule

// File: rtl/lcr_death_timer.sv
module lcr_death_timer #(
  parameter int DEATH_FRAMES = 180
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic count_en,
  output logic expired
);
  localparam int TW = (DEATH_FRAMES > 1) ? $clog2(DEATH_FRAMES + 1) : 1;
  localparam logic [TW-1:0] LAST = TW'(DEATH_FRAMES - 1);

  logic [TW-1:0] cnt_q;

  assign expired = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear)             cnt_q <= '0;
    else if (count_en && !expired) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lane_crossing_rules.sv
module lane_crossing_rules
  import lcr_pkg::*;
#(
  parameter int DEATH_FRAMES = 180,
  parameter int ROW_W        = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_tick,
  input  logic             bg_all_grass,
  input  logic             bg_any_road,
  input  logic             obj_any_car,
  input  logic             obj_any_log,
  input  logic             obj_any_goal,
  input  logic [ROW_W-1:0] row_idx,
  output logic             dead,
  output logic             respawn,
  output logic             on_log,
  output logic             win
);
  state_e   state_q, state_d;
  terrain_e terrain;
  logic     goal_hit, fatal, log_ride, expired;

  // Named internal events, brought out for the checker.
  logic alive_w, dead_state_w, death_now, win_now;

  lcr_terrain #(.ROW_W(ROW_W)) u_terrain (
    .bg_all_grass (bg_all_grass),
    .bg_any_road  (bg_any_road),
    .obj_any_car  (obj_any_car),
    .obj_any_log  (obj_any_log),
    .obj_any_goal (obj_any_goal),
    .row_idx      (row_idx),
    .terrain      (terrain),
    .goal_hit     (goal_hit),
    .fatal        (fatal),
    .log_ride     (log_ride)
  );

  assign alive_w      = is_alive(state_q);
  assign dead_state_w = (state_q == ST_DEAD);
  assign win_now      = alive_w && frame_tick && goal_hit;
  assign death_now    = alive_w && frame_tick && !goal_hit && fatal;

  lcr_death_timer #(.DEATH_FRAMES(DEATH_FRAMES)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .clear    (death_now || respawn),
    .count_en (dead_state_w && frame_tick),
    .expired  (expired)
  );

  // Mealy outputs
  assign dead    = dead_state_w || death_now;
  assign respawn = dead_state_w && frame_tick && expired;
  assign on_log  = alive_w && log_ride;
  assign win     = (state_q == ST_WIN);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_DEAD: if (respawn) state_d = ST_GRASS;
      ST_WIN:  state_d = ST_GRASS;
      default: begin
        if (frame_tick) begin
          if (win_now)        state_d = ST_WIN;
          else if (death_now) state_d = ST_DEAD;
          else                state_d = terrain_state(terrain);
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_GRASS;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/lcr_checker.sv
module lcr_checker #(
  parameter int DEATH_FRAMES = 180
) (
  input logic clk,
  input logic rst,
  input logic frame_tick,
  input logic bg_all_grass,
  input logic dead,
  input logic respawn,
  input logic on_log,
  input logic win,
  input logic alive_w,
  input logic dead_state_w
);
  localparam int TW = (DEATH_FRAMES > 1) ? $clog2(DEATH_FRAMES + 1) : 1;

  logic [TW-1:0] seen_q;

  // Independent count of strobes spent in the dead state.
  always_ff @(posedge clk) begin
    if (rst || !dead_state_w)            seen_q <= '0;
    else if (frame_tick && !respawn)     seen_q <= seen_q + 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!win && !respawn && !dead_state_w));

  assert_no_tick_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (alive_w && !frame_tick) |=> (alive_w && !win));

  assert_grass_safe_R3: assert property (@(posedge clk) disable iff (rst)
    (alive_w && bg_all_grass) |-> !dead);

  assert_log_saves_R6: assert property (@(posedge clk) disable iff (rst)
    on_log |-> !dead);

  assert_respawn_window_R8: assert property (@(posedge clk) disable iff (rst)
    respawn |-> (dead && frame_tick && seen_q == TW'(DEATH_FRAMES - 1)));

  assert_back_alive_R9: assert property (@(posedge clk) disable iff (rst)
    respawn |=> alive_w);

  assert_win_single_R10: assert property (@(posedge clk) disable iff (rst)
    win |=> (!win && alive_w));

  assert_win_not_dead_R11: assert property (@(posedge clk) disable iff (rst)
    win |-> !dead);
endmodule

bind lane_crossing_rules lcr_checker #(.DEATH_FRAMES(DEATH_FRAMES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .frame_tick   (frame_tick),
  .bg_all_grass (bg_all_grass),
  .dead         (dead),
  .respawn      (respawn),
  .on_log       (on_log),
  .win          (win),
  .alive_w      (alive_w),
  .dead_state_w (dead_state_w)
);

// File: tb/lane_crossing_rules_tb.sv
module lane_crossing_rules_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NFR        = 4;
  localparam int NV         = 22;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_tick = 1'b0;
  logic       bg_all_grass = 1'b1, bg_any_road = 1'b0;
  logic       obj_any_car = 1'b0, obj_any_log = 1'b0, obj_any_goal = 1'b0;
  logic [3:0] row_idx = 4'd5;
  logic       dead, respawn, on_log, win;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_crossing_rules #(.DEATH_FRAMES(NFR), .ROW_W(4)) u_dut (
    .clk(clk), .rst(rst), .frame_tick(frame_tick),
    .bg_all_grass(bg_all_grass), .bg_any_road(bg_any_road),
    .obj_any_car(obj_any_car), .obj_any_log(obj_any_log),
    .obj_any_goal(obj_any_goal), .row_idx(row_idx),
    .dead(dead), .respawn(respawn), .on_log(on_log), .win(win)
  );

  // {tick, all_grass, any_road, car, log, goal}_{row}_{dead, respawn, on_log, win}
  localparam logic [13:0] VEC [NV] = '{
    14'b010000_0101_0000, // 0  R1 idle grass
    14'b101100_0101_1000, // 1  R4 car on road
    14'b010000_0101_1000, // 2  R8
    14'b110000_0101_1000, // 3  R8
    14'b110000_0101_1000, // 4  R8
    14'b110000_0101_1000, // 5  R8
    14'b110000_0101_1100, // 6  R8 respawn
    14'b001100_0101_0000, // 7  R2 car without strobe
    14'b101000_0101_0000, // 8  R5 clear road
    14'b000010_0101_0010, // 9  R6 log, no strobe
    14'b100010_0101_0010, // 10 R6 log with strobe
    14'b100000_0101_1000, // 11 R7 drown
    14'b000010_0101_1000, // 12 R8 no on_log while dead
    14'b101100_0101_1000, // 13 R9 hazard while dead
    14'b110000_0101_1000, // 14 R9
    14'b100000_0101_1000, // 15 R9
    14'b110000_0101_1100, // 16 R9 respawn not stretched
    14'b110101_0101_0000, // 17 R3 grass safe, goal off row 0
    14'b100001_0000_0000, // 18 R11 goal over water
    14'b010000_0101_0001, // 19 R10 win pulse
    14'b010000_0101_0000, // 20 R10 pulse over
    14'b101100_0000_1000  // 21 R4 car on row 0
  };

  function automatic string tag_of(input int i);
    case (i)
      0: return "R1";   1, 21: return "R4";   7: return "R2";
      8: return "R5";   9, 10: return "R6";   11: return "R7";
      13, 14, 15, 16: return "R9";            17: return "R3";
      18: return "R11"; 19, 20: return "R10";
      default: return "R8";
    endcase
  endfunction

  task automatic drive(input logic [9:0] f);
    {frame_tick, bg_all_grass, bg_any_road, obj_any_car, obj_any_log, obj_any_goal} = f[9:4];
    row_idx = f[3:0];
  endtask

  task automatic check(input logic [3:0] exp, input string tag);
    logic [3:0] act;
    act = {dead, respawn, on_log, win};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {dead,respawn,on_log,win} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic [9:0] f, input logic [3:0] exp, input string tag);
    @(negedge clk);
    drive(f);
    #1;
    check(exp, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) step(VEC[i][13:4], VEC[i][3:0], tag_of(i));

    // R1: reset in the middle of a death clears state and timer
    @(negedge clk); rst = 1'b1; drive(10'b010000_0101);
    @(negedge clk); rst = 1'b0; #1; check(4'b0000, "R1");
    step(10'b101100_0101, 4'b1000, "R1");
    step(10'b110000_0101, 4'b1000, "R8");
    step(10'b110000_0101, 4'b1000, "R8");
    step(10'b110000_0101, 4'b1000, "R8");
    step(10'b110000_0101, 4'b1100, "R8");

    // R10: win cycle ignores a hazard, then returns to grass
    step(10'b110001_0000, 4'b0000, "R10");
    step(10'b101100_0101, 4'b0001, "R10");
    step(10'b010000_0101, 4'b0000, "R10");
    step(10'b100010_0101, 4'b0010, "R6");

    finish_run();
  end
endmodule